// File: doc/BRIEF.md
# Slot-Based Power Rail Sequencer

This block steps a bank of rail enable outputs on and off in a programmed order as a system moves between shutdown, active and sleep. Every transition runs through four consecutive time slots. Each of the four transitions (power-up, power-down, sleep-entry, sleep-exit) has its own slot-to-rail map, so any rail may switch in any slot of any transition, or not switch at all.

Two level inputs steer it. One asks for the active state (high) or shutdown (low). The other asks for sleep (high) or a return from sleep (low). Register inputs supply the four maps, a slot length code for rising transitions, a slot length code for falling transitions, a coarse-step select, a 2-bit forced-shutdown field and a keep-active flag. The keep-active flag is set by hardware and can be cleared by software. Slot time is counted in pulses of a `tick` input, one pulse per 250 µs base step. The outputs are the present drive level of every rail and the state code.

Top module: `rail_slot_sequencer`

## Requirements
- R1: During and after reset the state code is 0 (shutdown), every rail enable is low and the keep-active flag is low.
- R2: State codes are: 0 shutdown, 1 power-up, 2 power-down, 3 sleep, 4 sleep-entry, 5 sleep-exit, 7 active. Code 6 is invalid and never appears.
- R3: In shutdown a high `act_req` starts power-up, which ends in active. In active or sleep a low `act_req` starts power-down, which ends in shutdown. In active a high `sleep_req` starts sleep-entry, which ends in sleep. In sleep a low `sleep_req` starts sleep-exit, which ends in active.
- R4: Every transition runs slots 0, 1, 2, 3 in turn. Each slot lasts (code+1) ticks, or 4*(code+1) ticks when `long_step` is high. Power-up and sleep-exit use `rise_code`. Power-down and sleep-entry use `fall_code`. No slot advances on a cycle without a tick. With `tick` held high, a transition state lasts exactly 4 slot lengths in clock cycles.
- R5: Map bit s*12+i stands for rail i in slot s. Power-up and sleep-exit maps drive a marked rail high at the start of its slot. Power-down and sleep-entry maps drive it low. Slot 0 is applied on the clock edge that enters the transition state. During a rising transition no rail falls, and during a falling transition no rail rises.
- R6: A rail with no bit set in a transition's map keeps its level through that transition. Rail levels do not change while the state is shutdown, active or sleep.
- R7: A pulse on `hold_act_set` sets the keep-active flag. A pulse on `hold_act_clr` clears it, and the clear wins if both arrive together. While the flag is set, a high `sleep_req` does not start sleep-entry, and from sleep the block starts sleep-exit.
- R8: With `force_off` at 1 or 3, the block powers down from active or sleep and stays in shutdown regardless of `act_req`. Setting `force_off` to 0 returns control to `act_req`.
- R9: When `force_off` changes to 2, the block powers down and then stays in shutdown for RESUME_TICKS ticks. After that `act_req` controls it again. With `tick` held high, shutdown lasts RESUME_TICKS+1 cycles. Holding `force_off` at 2 does not start this again.
- R10: A change on `act_req` or `sleep_req` during a transition does not stop it. The input levels present once it completes choose the next transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slot time base pulse (one 250 µs step) |
| act_req | input | 1 | High requests active, low requests shutdown |
| sleep_req | input | 1 | High requests sleep, low requests wake |
| up_map | input | 48 | Power-up slot map, bit s*12+i |
| down_map | input | 48 | Power-down slot map |
| wake_map | input | 48 | Sleep-exit slot map |
| doze_map | input | 48 | Sleep-entry slot map |
| rise_code | input | 4 | Slot length code for power-up and sleep-exit |
| fall_code | input | 4 | Slot length code for power-down and sleep-entry |
| long_step | input | 1 | Selects 4-tick (1000 µs) slot step |
| force_off | input | 2 | 0 pin control, 1/3 held shutdown, 2 shutdown then resume |
| hold_act_set | input | 1 | Hardware pulse that sets keep-active |
| hold_act_clr | input | 1 | Software pulse that clears keep-active |
| rail_en | output | 12 | Present drive level of each rail |
| seq_state | output | 3 | State code |
| hold_act | output | 1 | Keep-active flag |

## Verification
The main function is first driven with structured maps, where each slot switches a distinct group of three rails. This makes slot 0's effect, the slot order and the full duration visible separately. Partial maps leave some rails unmapped, which separates "keeps its level" from "switched". Random maps, length codes and step selects are then run through complete up, sleep, wake and down cycles, so that rising and falling updates that interact across transitions are compared against a bench model. A stalled tick, input changes during a transition and each forced-shutdown mode cover the timing and override paths.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    localparam int CODE_W    = 4;
    localparam int STEP_MULT = 4;
    localparam int LEN_W     = $clog2((2 ** CODE_W) * STEP_MULT + 1);

    localparam logic [1:0] FO_PIN    = 2'd0;
    localparam logic [1:0] FO_HOLD   = 2'd1;
    localparam logic [1:0] FO_CYCLE  = 2'd2;
    localparam logic [1:0] FO_HOLD_B = 2'd3;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_RISE    = 3'd1,
        ST_FALL    = 3'd2,
        ST_NAP     = 3'd3,
        ST_NAP_IN  = 3'd4,
        ST_NAP_OUT = 3'd5,
        ST_BAD     = 3'd6,
        ST_ON      = 3'd7
    } rseq_state_e;

    function automatic logic is_idle(input rseq_state_e s);
        return (s == ST_OFF) || (s == ST_ON) || (s == ST_NAP);
    endfunction

    function automatic logic is_seq(input rseq_state_e s);
        return (s == ST_RISE) || (s == ST_FALL) || (s == ST_NAP_IN) || (s == ST_NAP_OUT);
    endfunction

    function automatic logic is_rising(input rseq_state_e s);
        return (s == ST_RISE) || (s == ST_NAP_OUT);
    endfunction

    function automatic logic [LEN_W-1:0] slot_len(input logic [CODE_W-1:0] code,
                                                   input logic coarse);
        logic [LEN_W-1:0] base;
        base = LEN_W'(code) + LEN_W'(1);
        return coarse ? base * LEN_W'(STEP_MULT) : base;
    endfunction

endpackage

// File: rtl/rseq_slot_timer.sv
module rseq_slot_timer
    import rseq_pkg::*;
#(
    parameter int N_SLOT = 4,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic              tick,
    input  logic [LEN_W-1:0]  len,
    output logic [SLOT_W-1:0] slot_q,
    output logic              slot_adv,
    output logic              seq_done
);

    logic [LEN_W-1:0] tcnt_q;
    logic             last_tick;
    logic             at_last_slot;

    always_comb begin
        at_last_slot = (slot_q == SLOT_W'(N_SLOT - 1));
        last_tick    = run && tick && ((tcnt_q + LEN_W'(1)) == len);
        slot_adv     = last_tick && !at_last_slot;
        seq_done     = last_tick && at_last_slot;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            tcnt_q <= '0;
            slot_q <= '0;
        end else if (run && tick) begin
            if (last_tick) begin
                tcnt_q <= '0;
                if (!at_last_slot)
                    slot_q <= slot_q + SLOT_W'(1);
            end else begin
                tcnt_q <= tcnt_q + LEN_W'(1);
            end
        end
    end

    // R4: a slot only moves on a tick or a fresh start
    p_slot_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_q != $past(slot_q)) |-> ($past(tick) || $past(start)));

endmodule

// File: rtl/rseq_rail_drive.sv
module rseq_rail_drive #(
    parameter int N_RAIL = 12,
    parameter int N_SLOT = 4,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     apply,
    input  logic                     rise,
    input  logic [N_SLOT*N_RAIL-1:0] map,
    input  logic [SLOT_W-1:0]        slot_idx,
    output logic [N_RAIL-1:0]        en_q
);

    logic [N_RAIL-1:0] rows [N_SLOT];
    logic [N_RAIL-1:0] pick;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_row
        assign rows[s] = map[s*N_RAIL +: N_RAIL];
    end

    assign pick = rows[slot_idx];

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (apply)
            en_q <= rise ? (en_q | pick) : (en_q & ~pick);
    end

endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
    import rseq_pkg::*;
#(
    parameter int RESUME_TICKS = 8,
    localparam int RC_W = $clog2(RESUME_TICKS + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        act_req,
    input  logic        sleep_req,
    input  logic [1:0]  force_off,
    input  logic        hold_set,
    input  logic        hold_clr,
    input  logic        seq_done,
    output rseq_state_e state_q,
    output rseq_state_e nxt,
    output logic        start,
    output logic        hold_act
);

    logic [1:0]      prev_force_q;
    logic            resume_wait_q;
    logic [RC_W-1:0] rcnt_q;
    logic            force_held;
    logic            cycle_trig;
    logic            act_ok;
    logic            want_nap;

    always_comb begin
        force_held = (force_off == FO_HOLD) || (force_off == FO_HOLD_B);
        cycle_trig = (force_off == FO_CYCLE) && (prev_force_q != FO_CYCLE);
        act_ok     = act_req && !force_held && !resume_wait_q && !cycle_trig;
        want_nap   = sleep_req && !hold_act;
    end

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_OFF:     if (act_ok) nxt = ST_RISE;
            ST_ON: begin
                if (!act_ok)       nxt = ST_FALL;
                else if (want_nap) nxt = ST_NAP_IN;
            end
            ST_NAP: begin
                if (!act_ok)        nxt = ST_FALL;
                else if (!want_nap) nxt = ST_NAP_OUT;
            end
            ST_RISE,
            ST_NAP_OUT: if (seq_done) nxt = ST_ON;
            ST_FALL:    if (seq_done) nxt = ST_OFF;
            ST_NAP_IN:  if (seq_done) nxt = ST_NAP;
            default:    nxt = ST_OFF;
        endcase
        start = is_idle(state_q) && (nxt != state_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_OFF;
            prev_force_q  <= FO_PIN;
            resume_wait_q <= 1'b0;
            rcnt_q        <= '0;
            hold_act      <= 1'b0;
        end else begin
            state_q      <= nxt;
            prev_force_q <= force_off;
            if (hold_clr)
                hold_act <= 1'b0;
            else if (hold_set)
                hold_act <= 1'b1;
            if (cycle_trig) begin
                resume_wait_q <= 1'b1;
                rcnt_q        <= '0;
            end else if (resume_wait_q && state_q == ST_OFF && tick) begin
                if (rcnt_q == RC_W'(RESUME_TICKS - 1)) begin
                    resume_wait_q <= 1'b0;
                    rcnt_q        <= '0;
                end else begin
                    rcnt_q <= rcnt_q + RC_W'(1);
                end
            end
        end
    end

    p_never_bad_r2: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_BAD);

    p_done_in_seq_r3: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> is_seq(state_q));

    p_hold_blocks_nap_r7: assert property (@(posedge clk) disable iff (rst)
        (hold_act && state_q == ST_ON) |=> (state_q != ST_NAP_IN));

    p_forced_stays_off_r8: assert property (@(posedge clk) disable iff (rst)
        (force_held && state_q == ST_OFF) |=> (state_q == ST_OFF));

    p_cycle_leaves_on_r9: assert property (@(posedge clk) disable iff (rst)
        (cycle_trig && state_q == ST_ON) |=> (state_q == ST_FALL));

endmodule

// File: rtl/rail_slot_sequencer.sv
module rail_slot_sequencer
    import rseq_pkg::*;
#(
    parameter int N_RAIL       = 12,
    parameter int N_SLOT       = 4,
    parameter int RESUME_TICKS = 8,
    localparam int MAP_W  = N_RAIL * N_SLOT,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              act_req,
    input  logic              sleep_req,
    input  logic [MAP_W-1:0]  up_map,
    input  logic [MAP_W-1:0]  down_map,
    input  logic [MAP_W-1:0]  wake_map,
    input  logic [MAP_W-1:0]  doze_map,
    input  logic [CODE_W-1:0] rise_code,
    input  logic [CODE_W-1:0] fall_code,
    input  logic              long_step,
    input  logic [1:0]        force_off,
    input  logic              hold_act_set,
    input  logic              hold_act_clr,
    output logic [N_RAIL-1:0] rail_en,
    output logic [2:0]        seq_state,
    output logic              hold_act
);

    rseq_state_e       state_q;
    rseq_state_e       nxt;
    rseq_state_e       target;
    logic              start;
    logic              slot_adv;
    logic              seq_done;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] apply_idx;
    logic [LEN_W-1:0]  len;
    logic [MAP_W-1:0]  map_sel;
    logic              apply;

    rseq_ctrl #(.RESUME_TICKS(RESUME_TICKS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .act_req   (act_req),
        .sleep_req (sleep_req),
        .force_off (force_off),
        .hold_set  (hold_act_set),
        .hold_clr  (hold_act_clr),
        .seq_done  (seq_done),
        .state_q   (state_q),
        .nxt       (nxt),
        .start     (start),
        .hold_act  (hold_act)
    );

    always_comb begin
        len = slot_len(is_rising(state_q) ? rise_code : fall_code, long_step);
        target = start ? nxt : state_q;
        unique case (target)
            ST_RISE:    map_sel = up_map;
            ST_NAP_OUT: map_sel = wake_map;
            ST_NAP_IN:  map_sel = doze_map;
            default:    map_sel = down_map;
        endcase
        apply     = start || slot_adv;
        apply_idx = start ? '0 : slot_q + SLOT_W'(1);
    end

    rseq_slot_timer #(.N_SLOT(N_SLOT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .run      (is_seq(state_q)),
        .tick     (tick),
        .len      (len),
        .slot_q   (slot_q),
        .slot_adv (slot_adv),
        .seq_done (seq_done)
    );

    rseq_rail_drive #(.N_RAIL(N_RAIL), .N_SLOT(N_SLOT)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .apply    (apply),
        .rise     (is_rising(target)),
        .map      (map_sel),
        .slot_idx (apply_idx),
        .en_q     (rail_en)
    );

    assign seq_state = state_q;

    p_rise_no_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (is_rising(state_q) && state_q == $past(state_q))
            |-> (($past(rail_en) & ~rail_en) == '0));

    p_fall_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_FALL || state_q == ST_NAP_IN) && state_q == $past(state_q))
            |-> ((~$past(rail_en) & rail_en) == '0));

    p_idle_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (is_idle(state_q) && is_idle($past(state_q))) |-> $stable(rail_en));

endmodule

// File: tb/tb_rail_slot_sequencer.sv
module tb_rail_slot_sequencer;

    localparam int RES = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        act_req = 1'b0;
    logic        sleep_req = 1'b0;
    logic [47:0] up_map = '0, down_map = '0, wake_map = '0, doze_map = '0;
    logic [3:0]  rise_code = '0, fall_code = '0;
    logic        long_step = 1'b0;
    logic [1:0]  force_off = 2'd0;
    logic        hold_act_set = 1'b0, hold_act_clr = 1'b0;
    logic [11:0] rail_en;
    logic [2:0]  seq_state;
    logic        hold_act;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rail_slot_sequencer #(.RESUME_TICKS(RES)) dut (
        .clk(clk), .rst(rst), .tick(tick), .act_req(act_req), .sleep_req(sleep_req),
        .up_map(up_map), .down_map(down_map), .wake_map(wake_map), .doze_map(doze_map),
        .rise_code(rise_code), .fall_code(fall_code), .long_step(long_step),
        .force_off(force_off), .hold_act_set(hold_act_set), .hold_act_clr(hold_act_clr),
        .rail_en(rail_en), .seq_state(seq_state), .hold_act(hold_act)
    );

    function automatic logic [11:0] m_up(input logic [11:0] e, input logic [47:0] m);
        for (int s = 0; s < 4; s++) e = e | m[s*12 +: 12];
        return e;
    endfunction

    function automatic logic [11:0] m_dn(input logic [11:0] e, input logic [47:0] m);
        for (int s = 0; s < 4; s++) e = e & ~m[s*12 +: 12];
        return e;
    endfunction

    function automatic int m_len(input logic [3:0] code, input logic coarse);
        return (int'(code) + 1) * (coarse ? 4 : 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_state(input int code, input int limit, output bit ok);
        for (int i = 0; i < limit && int'(seq_state) != code; i++) @(negedge clk);
        ok = (int'(seq_state) == code);
    endtask

    task automatic measure(input int code, output int cyc);
        cyc = 0;
        for (int i = 0; i < 5 && int'(seq_state) != code; i++) @(negedge clk);
        while (int'(seq_state) == code && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_set();
        hold_act_set = 1'b1; @(negedge clk); hold_act_set = 1'b0;
    endtask

    task automatic pulse_clr();
        hold_act_clr = 1'b1; @(negedge clk); hold_act_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] exp_en;
        int cyc;
        bit ok;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 state", int'(seq_state), 0);
        chk("R1 rails", int'(rail_en), 0);
        chk("R1 hold", int'(hold_act), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'(seq_state), 0);

        // directed power-up: slot s switches rails 3s..3s+2
        for (int s = 0; s < 4; s++) up_map[s*12 +: 12] = 12'h007 << (3*s);
        down_map = {12'hFFF, 36'h0};
        doze_map = {12'h000, 12'h030, 12'h00C, 12'h003};
        wake_map = {12'h000, 12'h007, 24'h0};
        rise_code = 4'd2; fall_code = 4'd0; long_step = 1'b0;
        act_req = 1'b1;
        @(negedge clk);
        chk("R3 enters power-up", int'(seq_state), 1);
        chk("R5 slot0 on entry edge", int'(rail_en), 12'h007);
        measure(1, cyc);
        chk("R4 power-up length", cyc, 4 * m_len(4'd2, 1'b0));
        chk("R3 reaches active", int'(seq_state), 7);
        chk("R5 all up", int'(rail_en), 12'hFFF);
        repeat (20) @(negedge clk);
        chk("R6 steady in active", int'(rail_en), 12'hFFF);

        // sleep entry with partial map, coarse step
        long_step = 1'b1;
        sleep_req = 1'b1;
        measure(4, cyc);
        chk("R4 sleep-entry length", cyc, 4 * m_len(4'd0, 1'b1));
        chk("R3 reaches sleep", int'(seq_state), 3);
        chk("R6 unmapped rails kept", int'(rail_en), 12'hFC0);
        long_step = 1'b0;
        sleep_req = 1'b0;
        measure(5, cyc);
        chk("R3 sleep-exit to active", int'(seq_state), 7);
        chk("R6 partial wake", int'(rail_en), 12'hFC7);

        // R7 keep-active
        pulse_set();
        chk("R7 flag set", int'(hold_act), 1);
        sleep_req = 1'b1;
        repeat (30) @(negedge clk);
        chk("R7 sleep ignored", int'(seq_state), 7);
        hold_act_set = 1'b1; hold_act_clr = 1'b1;
        @(negedge clk);
        hold_act_set = 1'b0; hold_act_clr = 1'b0;
        chk("R7 clear wins", int'(hold_act), 0);
        wait_state(3, 200, ok);
        chk("R7 sleeps after clear", int'(ok), 1);
        pulse_set();
        wait_state(7, 200, ok);
        chk("R7 set exits sleep", int'(ok), 1);
        sleep_req = 1'b0;
        pulse_clr();
        repeat (10) @(negedge clk);
        chk("R7 stays active", int'(seq_state), 7);

        // R10 request withdrawn mid-sequence
        sleep_req = 1'b1;
        wait_state(4, 20, ok);
        sleep_req = 1'b0;
        wait_state(3, 200, ok);
        chk("R10 entry completes", int'(ok), 1);
        wait_state(7, 200, ok);
        chk("R10 then wakes", int'(ok), 1);

        // R8 held forced shutdown
        force_off = 2'd1;
        wait_state(0, 300, ok);
        chk("R8 forced down", int'(ok), 1);
        repeat (40) @(negedge clk);
        chk("R8 ACT ignored", int'(seq_state), 0);
        force_off = 2'd3;
        repeat (10) @(negedge clk);
        chk("R8 mode 3 holds", int'(seq_state), 0);
        force_off = 2'd0;
        wait_state(7, 300, ok);
        chk("R8 release to pin", int'(ok), 1);

        // R9 shutdown then resume
        force_off = 2'd2;
        wait_state(0, 300, ok);
        chk("R9 powered down", int'(ok), 1);
        measure(0, cyc);
        chk("R9 resume delay", cyc, RES + 1);
        chk("R9 pin control back", int'(seq_state), 1);
        wait_state(7, 300, ok);
        repeat (40) @(negedge clk);
        chk("R9 no retrigger", int'(seq_state), 7);
        force_off = 2'd0;

        // R4 tick stall
        act_req = 1'b0;
        wait_state(0, 300, ok);
        chk("R5 all down", int'(rail_en), 0);
        tick = 1'b0;
        act_req = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 stall entry", int'(rail_en), 12'h007);
        repeat (30) @(negedge clk);
        chk("R4 stalled state", int'(seq_state), 1);
        chk("R4 stalled rails", int'(rail_en), 12'h007);
        tick = 1'b1;
        wait_state(7, 300, ok);
        act_req = 1'b0;
        wait_state(0, 300, ok);
        exp_en = 12'h000;
        chk("R5 known start", int'(rail_en), int'(exp_en));

        // random cycles against model
        for (int it = 0; it < 14; it++) begin
            up_map   = {$urandom, $urandom};
            down_map = {$urandom, $urandom};
            wake_map = {$urandom, $urandom};
            doze_map = {$urandom, $urandom};
            rise_code = 4'($urandom_range(0, 3));
            fall_code = 4'($urandom_range(0, 3));
            long_step = 1'($urandom);
            act_req = 1'b1;
            measure(1, cyc);
            exp_en = m_up(exp_en, up_map);
            chk("R4 rand up length", cyc, 4 * m_len(rise_code, long_step));
            chk("R5 rand up", int'(rail_en), int'(exp_en));
            sleep_req = 1'b1;
            measure(4, cyc);
            exp_en = m_dn(exp_en, doze_map);
            chk("R4 rand entry length", cyc, 4 * m_len(fall_code, long_step));
            chk("R6 rand entry", int'(rail_en), int'(exp_en));
            sleep_req = 1'b0;
            measure(5, cyc);
            exp_en = m_up(exp_en, wake_map);
            chk("R5 rand wake", int'(rail_en), int'(exp_en));
            act_req = 1'b0;
            measure(2, cyc);
            exp_en = m_dn(exp_en, down_map);
            chk("R3 rand down state", int'(seq_state), 0);
            chk("R5 rand down", int'(rail_en), int'(exp_en));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule